// File: doc/BRIEF.md
# Switch-Paged System ROM Bank Selector

This block places a 12 KB system ROM window at the top of a 16-bit CPU address space (0xD000 to 0xFFFF) and backs it with one of four banks in a 48 KB physical ROM image. The window is made of six 2 KB slices, and each bank supplies all six of them.

The bank number is never written as a value. It is a two-bit page register, and each bit has its own pair of I/O soft-switch addresses: one pair clears the bit and the other sets it. Both reads and writes of a soft-switch address take effect. A soft-switch read returns 0x00. Two further I/O write offsets are accepted and change nothing.

The CPU side is purely combinational. The block turns the CPU address and the current page into a physical ROM address and a ROM enable. The I/O side changes the page at the clock edge that ends the access, so the very next ROM fetch uses the new bank.

Top module: `rom_bank_map`

## Requirements
- R1: After reset the page register is 0, so a read fetch at 0xD000 gives rom_addr 0x0000.
- R2: An I/O access at offset 0x58 clears page bit 0 and leaves page bit 1 as it was.
- R3: An I/O access at offset 0x59 sets page bit 0 and leaves page bit 1 as it was.
- R4: An I/O access at offset 0x5A clears page bit 1 and leaves page bit 0 as it was.
- R5: An I/O access at offset 0x5B sets page bit 1 and leaves page bit 0 as it was.
- R6: Offsets 0x58 to 0x5B act on both reads (io_wr=0) and writes (io_wr=1); the access is acknowledged (io_ack=1), and a read returns io_rdata 0x00. Any access that is not an acknowledged read shows io_rdata 0xFF.
- R7: A write to offset 0x0C or 0x0E is acknowledged and leaves the page unchanged. A read of these offsets, or any access to another offset outside 0x58 to 0x5B, gets io_ack=0 and leaves the page unchanged.
- R8: For a read fetch (cpu_wr=0) with cpu_addr from 0xD000 to 0xFFFF, rom_en=1 and rom_addr = page*12288 + (cpu_addr - 0xD000).
- R9: A fetch with cpu_addr below 0xD000 gives rom_en=0.
- R10: A write (cpu_wr=1) in 0xD000 to 0xFFFF gives rom_en=0 and leaves the page unchanged.
- R11: A soft-switch access sampled at a clock edge sets the page used by the fetch in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_strb | input | 1 | I/O page access in this cycle |
| io_wr | input | 1 | 1 for an I/O write, 0 for a read |
| io_off | input | 8 | Low byte of the I/O address |
| io_ack | output | 1 | Access is decoded by this block |
| io_rdata | output | 8 | Read data for an acknowledged read |
| cpu_addr | input | 16 | CPU address of the memory fetch |
| cpu_wr | input | 1 | 1 if the memory access is a write |
| rom_en | output | 1 | ROM selected for this fetch |
| rom_addr | output | 16 | Physical byte address in the ROM image |

## Verification
The page register is the only state, and it is visible only through rom_addr. A fetch at the window base shows the page directly as a multiple of 12288. A wrong bit, such as a set that also clears its neighbour or a decode of the wrong offset, shows up in the first fetch after the faulty access, one cycle later. The bench keeps a reference page and compares every cycle's fetch against it. A corrupted bank therefore fails no later than the next fetch, and an ignored access that wrongly moves the page is caught the same way.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
   // Kind of access decoded on the I/O page
   typedef enum logic [1:0] {
      IO_NONE  = 2'd0,
      IO_SWTCH = 2'd1,
      IO_NOP   = 2'd2
   } io_kind_e;

   function automatic int unsigned rbm_clog2(input longint unsigned v);
      int unsigned r;
      longint unsigned t;
      r = 0;
      t = 1;
      while (t < v) begin
         t = t << 1;
         r++;
      end
      return r;
   endfunction
endpackage

// File: rtl/rbm_decode.sv
module rbm_decode
   import rbm_pkg::*;
#(
   parameter int unsigned PAGE_W  = 2,
   parameter logic [7:0]  SW_BASE = 8'h58,
   parameter int unsigned NOP_N   = 2,
   parameter logic [8*NOP_N-1:0] NOP_OFFS = {8'h0E, 8'h0C}
) (
   input  logic              strb_i,
   input  logic              wr_i,
   input  logic [7:0]        off_i,
   output logic [PAGE_W-1:0] set_o,
   output logic [PAGE_W-1:0] clr_o,
   output io_kind_e          kind_o
);
   localparam int unsigned SW_N = 2 * PAGE_W;

   initial begin
      assert (PAGE_W >= 1) else $error("PAGE_W must be at least 1");
      assert (int'(SW_BASE) + SW_N <= 256) else $error("switch offsets overflow the I/O page");
   end

   logic [SW_N-1:0]  sw_hit;
   logic [NOP_N-1:0] nop_hit;

   // switch i drives page bit i/2; even offsets clear, odd offsets set
   for (genvar i = 0; i < SW_N; i++) begin : g_sw
      assign sw_hit[i] = strb_i && (off_i == 8'(int'(SW_BASE) + i));
   end

   for (genvar b = 0; b < PAGE_W; b++) begin : g_bit
      assign clr_o[b] = sw_hit[2*b];
      assign set_o[b] = sw_hit[2*b+1];
   end

   for (genvar n = 0; n < NOP_N; n++) begin : g_nop
      assign nop_hit[n] = strb_i && wr_i && (off_i == NOP_OFFS[8*n +: 8]);
   end

   always_comb begin
      if (|sw_hit)       kind_o = IO_SWTCH;
      else if (|nop_hit) kind_o = IO_NOP;
      else               kind_o = IO_NONE;
   end
endmodule

// File: rtl/rbm_page_reg.sv
module rbm_page_reg #(
   parameter int unsigned PAGE_W    = 2,
   parameter logic [PAGE_W-1:0] RST_PAGE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PAGE_W-1:0] set_i,
   input  logic [PAGE_W-1:0] clr_i,
   output logic [PAGE_W-1:0] page_o
);
   // each bit is an independent set/clear flop
   for (genvar b = 0; b < PAGE_W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        page_o[b] <= RST_PAGE[b];
         else if (set_i[b]) page_o[b] <= 1'b1;
         else if (clr_i[b]) page_o[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/rbm_xlate.sv
module rbm_xlate
   import rbm_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned PAGE_W  = 2,
   parameter int unsigned WIN_W   = 11,
   parameter int unsigned WIN_N   = 6,
   parameter logic [ADDR_W-1:0] BASE = 16'hD000,
   localparam int unsigned BANK_B = WIN_N << WIN_W,
   localparam int unsigned ROM_AW = rbm_clog2(longint'(BANK_B) << PAGE_W)
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [PAGE_W-1:0] page_i,
   output logic              en_o,
   output logic [ROM_AW-1:0] rom_addr_o
);
   localparam int unsigned OFS_W = rbm_clog2(longint'(BANK_B));
   localparam bit BANK_POW2 = ((1 << OFS_W) == BANK_B);

   initial begin
      assert (WIN_N >= 1) else $error("WIN_N must be at least 1");
      assert (longint'(BASE) + BANK_B <= (longint'(1) << ADDR_W))
         else $error("ROM region runs past the address space");
   end

   logic [ADDR_W-1:0] rel;
   logic              in_win;

   assign rel    = addr_i - BASE;
   assign in_win = (addr_i >= BASE) && (longint'(rel) < longint'(BANK_B));
   assign en_o   = in_win && !wr_i;

   if (BANK_POW2) begin : g_concat
      // power-of-two bank: page bits sit above the offset
      assign rom_addr_o = ROM_AW'({page_i, rel[OFS_W-1:0]});
   end else begin : g_mult
      localparam logic [ROM_AW-1:0] BANK_L = ROM_AW'(BANK_B);
      logic [ROM_AW-1:0] bank_base;
      assign bank_base  = ROM_AW'(page_i) * BANK_L;
      assign rom_addr_o = bank_base + ROM_AW'(rel[OFS_W-1:0]);
   end
endmodule

// File: rtl/rom_bank_map.sv
module rom_bank_map
   import rbm_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned PAGE_W   = 2,
   parameter int unsigned WIN_W    = 11,
   parameter int unsigned WIN_N    = 6,
   parameter logic [15:0] BASE     = 16'hD000,
   parameter logic [7:0]  SW_BASE  = 8'h58,
   parameter logic [7:0]  SW_RDATA = 8'h00,
   parameter logic [7:0]  IDLE_RDATA = 8'hFF,
   localparam int unsigned ROM_AW  = rbm_clog2(longint'(WIN_N << WIN_W) << PAGE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_strb,
   input  logic              io_wr,
   input  logic [7:0]        io_off,
   output logic              io_ack,
   output logic [7:0]        io_rdata,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_wr,
   output logic              rom_en,
   output logic [ROM_AW-1:0] rom_addr
);
   localparam int unsigned BANK_B = WIN_N << WIN_W;

   logic [PAGE_W-1:0] sw_set, sw_clr, page;
   io_kind_e          kind;

   rbm_decode #(.PAGE_W(PAGE_W), .SW_BASE(SW_BASE)) u_dec (
      .strb_i(io_strb), .wr_i(io_wr), .off_i(io_off),
      .set_o(sw_set), .clr_o(sw_clr), .kind_o(kind)
   );

   rbm_page_reg #(.PAGE_W(PAGE_W)) u_page (
      .clk(clk), .rst_n(rst_n), .set_i(sw_set), .clr_i(sw_clr), .page_o(page)
   );

   rbm_xlate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WIN_W(WIN_W), .WIN_N(WIN_N),
               .BASE(ADDR_W'(BASE))) u_xl (
      .addr_i(cpu_addr), .wr_i(cpu_wr), .page_i(page),
      .en_o(rom_en), .rom_addr_o(rom_addr)
   );

   assign io_ack   = (kind != IO_NONE);
   assign io_rdata = (io_ack && !io_wr) ? SW_RDATA : IDLE_RDATA;

   // R2..R5: one bit moves, the other holds
   a_r2_clr_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      (io_strb && io_off == SW_BASE) |=> (!page[0] && page[PAGE_W-1:1] == $past(page[PAGE_W-1:1])));
   a_r3_set_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      (io_strb && io_off == SW_BASE + 8'd1) |=> (page[0] && page[PAGE_W-1:1] == $past(page[PAGE_W-1:1])));
   a_r4_clr_bit1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_strb && io_off == SW_BASE + 8'd2) |=> (!page[1] && page[0] == $past(page[0])));
   a_r5_set_bit1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_strb && io_off == SW_BASE + 8'd3) |=> (page[1] && page[0] == $past(page[0])));
   // R6: switch reads answer with the fixed value
   a_r6_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (io_strb && !io_wr && io_off >= SW_BASE && io_off <= SW_BASE + 8'd3) |-> (io_ack && io_rdata == SW_RDATA));
   // R7/R10: non-switch traffic keeps the page
   a_r7_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_strb && io_off >= SW_BASE && io_off <= SW_BASE + 8'd3) |=> $stable(page));
   // R8: physical address stays in the image
   a_r8_in_image: assert property (@(posedge clk) disable iff (!rst_n)
      rom_en |-> (longint'(rom_addr) < (longint'(BANK_B) << PAGE_W)));
   // R9: low addresses never select the ROM
   a_r9_below: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr < ADDR_W'(BASE)) |-> !rom_en);
endmodule

// File: tb/sim_rom_bank_map.sv
`timescale 1ns/1ps
module sim_rom_bank_map;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_strb = 1'b0, io_wr = 1'b0, cpu_wr = 1'b0;
   logic [7:0]  io_off = 8'h00;
   logic [15:0] cpu_addr = 16'h0000;
   logic        io_ack, rom_en;
   logic [7:0]  io_rdata;
   logic [15:0] rom_addr;

   int total = 0, bad = 0;
   logic [1:0] mpage = 2'd0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rom_bank_map u0 (.*);

   function automatic logic exp_en(input logic [15:0] a, input logic w);
      return (a >= 16'hD000) && !w;
   endfunction
   function automatic logic [15:0] exp_addr(input logic [15:0] a, input logic [1:0] p);
      return 16'(int'(p) * 12288 + int'(a) - 32'hD000);
   endfunction
   function automatic logic exp_ack(input logic s, input logic w, input logic [7:0] o);
      return s && ((o >= 8'h58 && o <= 8'h5B) || (w && (o == 8'h0C || o == 8'h0E)));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one cycle, check the combinational outputs, advance the model
   task automatic cyc(input string req, input logic s, input logic w, input logic [7:0] o,
                      input logic [15:0] a, input logic cw);
      @(negedge clk);
      io_strb = s; io_wr = w; io_off = o; cpu_addr = a; cpu_wr = cw;
      #3;
      chk({req, " rom_en"}, 32'(rom_en), 32'(exp_en(a, cw)));
      if (exp_en(a, cw)) chk({req, " rom_addr"}, 32'(rom_addr), 32'(exp_addr(a, mpage)));
      chk({req, " io_ack"}, 32'(io_ack), 32'(exp_ack(s, w, o)));
      chk({req, " io_rdata"}, 32'(io_rdata),
          (exp_ack(s, w, o) && !w) ? 32'h00 : 32'hFF);
      if (s) begin
         case (o)
            8'h58: mpage[0] = 1'b0;
            8'h59: mpage[0] = 1'b1;
            8'h5A: mpage[1] = 1'b0;
            8'h5B: mpage[1] = 1'b1;
            default: ;
         endcase
      end
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      cyc("R1 reset page", 0, 0, 8'h00, 16'hD000, 0);
      chk("R1 base", 32'(rom_addr), 32'h0000);
      cyc("R3 read 59", 1, 0, 8'h59, 16'hE123, 0);
      cyc("R11 next fetch", 0, 0, 8'h00, 16'hD000, 0);
      chk("R11 page1 base", 32'(rom_addr), 32'd12288);
      cyc("R5 write 5B", 1, 1, 8'h5B, 16'h0000, 0);
      cyc("R8 top byte", 0, 0, 8'h00, 16'hFFFF, 0);
      chk("R8 top", 32'(rom_addr), 32'd49151);
      cyc("R2 write 58", 1, 1, 8'h58, 16'hD7FF, 0);
      cyc("R2 page2", 0, 0, 8'h00, 16'hD800, 0);
      chk("R2 page2 slice", 32'(rom_addr), 32'd24576 + 32'd2048);
      cyc("R4 read 5A", 1, 0, 8'h5A, 16'hF800, 0);
      cyc("R7 write 0C", 1, 1, 8'h0C, 16'hD000, 0);
      cyc("R7 write 0E", 1, 1, 8'h0E, 16'hD000, 0);
      cyc("R7 read 0C", 1, 0, 8'h0C, 16'hD000, 0);
      chk("R7 page kept", 32'(rom_addr), 32'd0);
      cyc("R9 below", 0, 0, 8'h00, 16'hCFFF, 0);
      cyc("R10 rom write", 0, 0, 8'h00, 16'hE000, 1);
      cyc("R10 page kept", 0, 0, 8'h00, 16'hE000, 0);
      cyc("R6 set both", 1, 1, 8'h59, 16'h0000, 0);
      cyc("R6 set both b", 1, 0, 8'h5B, 16'h0000, 0);
      cyc("R6 page3", 0, 0, 8'h00, 16'hD000, 0);
      chk("R6 page3 base", 32'(rom_addr), 32'd36864);
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] o;
         logic [15:0] a;
         int k = int'($urandom_range(0, 9));
         o = (k < 5) ? 8'(8'h58 + $urandom_range(0, 3))
           : (k < 7) ? ((k == 5) ? 8'h0C : 8'h0E) : 8'($urandom);
         a = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'(16'hD000 + $urandom_range(0, 12287));
         cyc("R8 random", 1'($urandom), 1'($urandom), o, a, ($urandom_range(0, 7) == 0));
      end
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule